// File: doc/BRIEF.md
# Bouncing One-Hot Shuttle Register

This block keeps a single active bit inside a register of 8×N stages and walks it one stage per enabled clock. When the bit reaches the last stage it turns around and walks back; when it reaches stage 0 it turns again. Each tap line therefore goes high once on the rising pass and once on the falling pass. The same tap sets the level on both sides of each turnaround, so the pattern is symmetric about its peak without any extra matching.

The tap lines drive an external weighting network. A direction flag reports which way the bit is travelling. A sign flag changes at the start of each new sweep so that an external stage can invert every other sweep. A parameter selects whether each end stage is held for one enabled clock or for two. This gives a sweep of 16N−2 or 16N distinct steps. If the register is ever found with no bit set, or with several bits set, it is put back into its reset state on the next clock.

Top module: `shuttle_bounce`

## Requirements
- R1: After a synchronous reset, tap 0 is the only high tap, `dir_up_o` is 1 (travelling toward the last stage) and `sign_neg_o` is 0 (positive half).
- R2: From reset onward, exactly one tap line is high in every cycle.
- R3: On each enabled clock that is not an end dwell, the high tap moves by exactly one stage toward the travelling direction.
- R4: With DWELL=0 the bit turns at both ends without pausing. The tap index after k enabled clocks follows 0,1,…,8N−1,8N−2,…,1,0,1,… with a period of 16N−2 clocks.
- R5: With DWELL=1 each end stage stays high for two enabled clocks. This includes stage 0 directly after reset. The period is 16N clocks.
- R6: `dir_up_o` changes only on the clock at which the bit leaves an end stage. It becomes 0 on leaving the last stage and 1 on leaving stage 0 after a return.
- R7: `sign_neg_o` inverts on each clock at which the bit leaves stage 0 after having returned to it. It does not change on the first departure after reset, nor at any other time.
- R8: While `en_i` is 0, the taps, `dir_up_o` and `sign_neg_o` keep their values.
- R9: Reset takes precedence over `en_i` and returns all outputs to the R1 state on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Step enable |
| tap_o | output | 8*N_GROUPS | One-hot tap lines, bit 0 is the start stage |
| dir_up_o | output | 1 | 1 while travelling toward the last stage |
| sign_neg_o | output | 1 | Half-sweep sign, 1 for the inverted sweep |

## Verification
The bench builds two copies side by side.

- **N_GROUPS=1 with DWELL=1:** 8 stages, so a full 16-step sweep comes round every 16 enabled clocks. This brings the doubled end stays and their interaction with the reset position into reach within a few cycles.
- **N_GROUPS=2 with DWELL=0:** 16 stages with immediate turnaround. It exercises the 30-step period and the wider shift path.

Random enable patterns push both copies through many sweeps and sign inversions. Directed stretches cover enable held low and reset arriving mid-sweep with enable high.

// File: rtl/shuttle_pkg.sv
package shuttle_pkg;

  // Turnaround state carried beside the token register.
  typedef struct packed {
    logic dir_up;    // travelling toward the last stage
    logic held;      // the end dwell clock has already been spent
    logic sign_neg;  // inverted half sweep
  } turn_state_t;

  // Direction for the next move: ends force a turn, otherwise keep going.
  function automatic logic next_dir(input logic cur_up, input logic at_first,
                                    input logic at_last);
    if (at_last) return 1'b0;
    if (at_first) return 1'b1;
    return cur_up;
  endfunction

  // The sign inverts when the token departs stage 0 after a downward return.
  function automatic logic sweep_restart(input logic moving, input logic at_first,
                                         input logic cur_up);
    return moving && at_first && !cur_up;
  endfunction

endpackage

// File: rtl/shuttle_onehot_chk.sv
module shuttle_onehot_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic         ok_o
);
  logic [W-1:0] seen;
  logic [W-1:0] multi;

  assign seen[0]  = vec_i[0];
  assign multi[0] = 1'b0;

  generate
    for (genvar i = 1; i < W; i++) begin : g_scan
      assign seen[i]  = seen[i-1] | vec_i[i];
      assign multi[i] = multi[i-1] | (seen[i-1] & vec_i[i]);
    end
  endgenerate

  assign ok_o = seen[W-1] & ~multi[W-1];
endmodule

// File: rtl/shuttle_token_reg.sv
module shuttle_token_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         load_home_i,
  input  logic         shift_en_i,
  input  logic         shift_up_i,
  output logic [W-1:0] tap_o
);
  logic [W-1:0] tap_q;
  logic [W-1:0] tap_nxt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      logic from_below;
      logic from_above;
      if (i == 0) begin : g_lo_end
        assign from_below = 1'b0;
      end else begin : g_lo_mid
        assign from_below = tap_q[i-1];
      end
      if (i == W - 1) begin : g_hi_end
        assign from_above = 1'b0;
      end else begin : g_hi_mid
        assign from_above = tap_q[i+1];
      end
      assign tap_nxt[i] = shift_up_i ? from_below : from_above;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (load_home_i)     tap_q <= W'(1);
    else if (shift_en_i) tap_q <= tap_nxt;
  end

  assign tap_o = tap_q;

  // R3: a step upward moves the token exactly one stage higher.
  p_step_up_r3: assert property (@(posedge clk_i) disable iff (load_home_i)
    (shift_en_i && shift_up_i && !tap_q[W-1]) |=> (tap_q == ($past(tap_q) << 1)));
  // R3: a step downward moves the token exactly one stage lower.
  p_step_dn_r3: assert property (@(posedge clk_i) disable iff (load_home_i)
    (shift_en_i && !shift_up_i && !tap_q[0]) |=> (tap_q == ($past(tap_q) >> 1)));
endmodule

// File: rtl/shuttle_turn_ctrl.sv
module shuttle_turn_ctrl
  import shuttle_pkg::*;
#(
  parameter int DWELL = 1
) (
  input  logic clk_i,
  input  logic home_i,
  input  logic en_i,
  input  logic at_first_i,
  input  logic at_last_i,
  output logic move_o,
  output logic step_up_o,
  output logic hold_o,
  output logic restart_o,
  output logic dir_up_o,
  output logic sign_neg_o
);
  turn_state_t st_q;
  logic        hold_now;

  generate
    if (DWELL != 0) begin : g_dwell
      assign hold_now = (at_first_i | at_last_i) & ~st_q.held;
    end else begin : g_nodwell
      assign hold_now = 1'b0;
    end
  endgenerate

  assign move_o    = en_i & ~hold_now;
  assign hold_o    = en_i & hold_now;
  assign step_up_o = next_dir(st_q.dir_up, at_first_i, at_last_i);
  assign restart_o = sweep_restart(move_o, at_first_i, st_q.dir_up);

  always_ff @(posedge clk_i) begin
    if (home_i) begin
      st_q <= '{dir_up: 1'b1, held: 1'b0, sign_neg: 1'b0};
    end else if (en_i) begin
      st_q.held <= (DWELL != 0) ? hold_now : 1'b0;
      if (move_o) st_q.dir_up <= step_up_o;
      if (restart_o) st_q.sign_neg <= ~st_q.sign_neg;
    end
  end

  assign dir_up_o   = st_q.dir_up;
  assign sign_neg_o = st_q.sign_neg;

  // R8: nothing in the turnaround state moves while disabled.
  p_idle_r8: assert property (@(posedge clk_i) disable iff (home_i)
    !en_i |=> ($stable(dir_up_o) && $stable(sign_neg_o)));
  // R6: departing the last stage always leaves the direction pointing down.
  p_turn_down_r6: assert property (@(posedge clk_i) disable iff (home_i)
    (move_o && at_last_i) |=> !dir_up_o);
endmodule

// File: rtl/shuttle_bounce.sv
module shuttle_bounce #(
  parameter int N_GROUPS = 1,
  parameter int DWELL    = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    en_i,
  output logic [8*N_GROUPS-1:0]   tap_o,
  output logic                    dir_up_o,
  output logic                    sign_neg_o
);
  localparam int STAGES = 8 * N_GROUPS;

  logic [STAGES-1:0] tap;
  logic token_ok;
  logic go_home;
  logic at_first_evt;
  logic at_last_evt;
  logic move_evt;
  logic step_up;
  logic hold_evt;
  logic restart_evt;

  assign at_first_evt = tap[0];
  assign at_last_evt  = tap[STAGES-1];
  assign go_home      = rst_i | ~token_ok;

  shuttle_onehot_chk #(.W(STAGES)) u_chk (
    .vec_i (tap),
    .ok_o  (token_ok)
  );

  shuttle_turn_ctrl #(.DWELL(DWELL)) u_ctrl (
    .clk_i      (clk_i),
    .home_i     (go_home),
    .en_i       (en_i),
    .at_first_i (at_first_evt),
    .at_last_i  (at_last_evt),
    .move_o     (move_evt),
    .step_up_o  (step_up),
    .hold_o     (hold_evt),
    .restart_o  (restart_evt),
    .dir_up_o   (dir_up_o),
    .sign_neg_o (sign_neg_o)
  );

  shuttle_token_reg #(.W(STAGES)) u_tok (
    .clk_i       (clk_i),
    .load_home_i (go_home),
    .shift_en_i  (move_evt),
    .shift_up_i  (step_up),
    .tap_o       (tap)
  );

  assign tap_o = tap;

  // R2: exactly one tap is high once reset has been applied.
  p_single_tap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(tap) == 1);
  // R9: reset lands in the home state whatever the enable does.
  p_reset_home_r9: assert property (@(posedge clk_i)
    rst_i |=> (tap == STAGES'(1) && dir_up_o && !sign_neg_o));
  // R7: the sign inverts on a sweep restart and only then.
  p_sign_flip_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_evt |=> (sign_neg_o != $past(sign_neg_o)));
  p_sign_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!restart_evt && token_ok) |=> $stable(sign_neg_o));
  // R8: a disabled clock leaves the taps where they are.
  p_tap_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && token_ok) |=> $stable(tap));

  generate
    if (DWELL != 0) begin : g_dwell_chk
      // R5: the dwell clock keeps the token on its end stage.
      p_end_dwell_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_evt |=> $stable(tap));
    end
  endgenerate
endmodule

// File: tb/shuttle_bounce_test.sv
`timescale 1ns/1ps
module shuttle_bounce_test;
  localparam int SA = 8;   // copy A: N_GROUPS=1, DWELL=1
  localparam int SB = 16;  // copy B: N_GROUPS=2, DWELL=0

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [SA-1:0] tap_a;
  logic [SB-1:0] tap_b;
  logic dir_a, dir_b, sgn_a, sgn_b;

  int n_checks = 0;
  int n_fail   = 0;
  int ka = 0;
  int kb = 0;

  always #2.5 clk = ~clk;

  shuttle_bounce #(.N_GROUPS(1), .DWELL(1)) uut (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .tap_o(tap_a), .dir_up_o(dir_a), .sign_neg_o(sgn_a));

  shuttle_bounce #(.N_GROUPS(2), .DWELL(0)) uut_d0 (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .tap_o(tap_b), .dir_up_o(dir_b), .sign_neg_o(sgn_b));

  // Expected tap index after k enabled clocks, from the sequence in R4/R5.
  function automatic int want_pos(int k, int s, int dw);
    int p = 2 * s - 2 + 2 * dw;
    int m = k % p;
    if (dw == 0) return (m < s) ? m : p - m;
    if (m == 0) return 0;
    if (m <= s) return m - 1;
    return 2 * s - m;
  endfunction

  // Expected direction flag (R6): turns only on leaving an end.
  function automatic int want_dir(int k, int s, int dw);
    int p = 2 * s - 2 + 2 * dw;
    int m = k % p;
    if (k < 1 + dw) return 1;
    if (dw == 0) return (m >= 1 && m <= s - 1) ? 1 : 0;
    return (m >= 2 && m <= s + 1) ? 1 : 0;
  endfunction

  // Expected sign (R7): first restart after one full period plus the first leave.
  function automatic int want_sign(int k, int s, int dw);
    int p = 2 * s - 2 + 2 * dw;
    int lead = 1 + dw;
    if (k < lead) return 0;
    return ((k - lead) / p) % 2;
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R5 copy A tap", longint'(tap_a), longint'(1) << want_pos(ka, SA, 1));
    chk("R4 copy B tap", longint'(tap_b), longint'(1) << want_pos(kb, SB, 0));
    chk("R2 copy A one-hot", $countones(tap_a), 1);
    chk("R2 copy B one-hot", $countones(tap_b), 1);
    chk("R6 copy A dir", longint'(dir_a), want_dir(ka, SA, 1));
    chk("R6 copy B dir", longint'(dir_b), want_dir(kb, SB, 0));
    chk("R7 copy A sign", longint'(sgn_a), want_sign(ka, SA, 1));
    chk("R7 copy B sign", longint'(sgn_b), want_sign(kb, SB, 0));
  endtask

  task automatic step(input logic r, input logic e);
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) begin ka = 0; kb = 0; end
    else if (e) begin ka++; kb++; end
    @(negedge clk);
    check_all();
  endtask

  task automatic check_home(input string tag);
    chk({tag, " tap A"}, longint'(tap_a), 1);
    chk({tag, " tap B"}, longint'(tap_b), 1);
    chk({tag, " dir"}, longint'({dir_a, dir_b}), 3);
    chk({tag, " sign"}, longint'({sgn_a, sgn_b}), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [SA-1:0] ha;
    logic [SB-1:0] hb;
    logic hd, hs;
    void'($urandom(32'd20111016));
    @(negedge clk);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check_home("R1");

    // R3 R4 R5: several full sweeps with enable held high.
    for (int i = 0; i < 70; i++) step(1'b0, 1'b1);

    // R8: enable low freezes every output.
    ha = tap_a; hb = tap_b; hd = dir_b; hs = sgn_a;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b0);
      chk("R8 hold A", longint'(tap_a), longint'(ha));
      chk("R8 hold B", longint'(tap_b), longint'(hb));
      chk("R8 hold dir", longint'(dir_b), longint'(hd));
      chk("R8 hold sign", longint'(sgn_a), longint'(hs));
    end

    // R9: reset mid-sweep with enable high wins.
    for (int i = 0; i < 11; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check_home("R9");

    // R5: dwell at stage 0 right after reset.
    step(1'b0, 1'b1);
    chk("R5 reset dwell", longint'(tap_a), 1);

    // Random enable, occasional reset.
    for (int i = 0; i < 3000; i++) begin
      logic r = (($urandom % 400) == 0);
      logic e = (($urandom % 4) != 0);
      step(r, e);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule